// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block keeps a record of loads that were hoisted above stores. When a hoisted load issues, the block records its destination register tag and its address. Every store that follows is compared against all live records at once, and any record whose address shares the store's 8-byte granule is cancelled. A later check names a register tag. The block then reports whether that load's record is still live. If the record was cancelled, or never existed, the check fails and the pipeline must run recovery code.

The table is fully associative and has eight slots by default. It is searched in two ways. A check and an insert search it by register tag. A store searches it by address. A new hoisted load to a tag that is already present reuses that slot. When no slot is free, a round-robin pointer picks the slot to evict. Each check is answered one cycle after it is issued, together with a response-valid pulse.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table holds no live records, and `rsp_valid` and `rsp_ok` are low. A check issued right after reset reports failure.
- R2: A check issued in cycle t gives `rsp_valid` high for exactly cycle t+1. In that cycle `rsp_ok` is 1 only if a live record with the checked tag existed at the start of cycle t, before any store or insert of cycle t takes effect. When `rsp_valid` is low, `rsp_ok` is low.
- R3: An insert (`ld_valid`) makes its tag pass every later check until the record is cancelled or evicted. A passing check leaves the record live.
- R4: A store (`st_valid`) cancels every live record whose address bits [63:3] equal the store's address bits [63:3], whatever the low three bits are. Records in other granules stay live.
- R5: An insert whose tag already has a live record overwrites that record's address and does not create a second record. A store to the old address then no longer affects it. At no time do two live records hold the same tag.
- R6: When a store and an insert occur in the same cycle, the store's cancellation is applied first. The newly inserted record stays live even if its address is in the store's granule.
- R7: An insert with a new tag takes the lowest-numbered free slot. When all slots are live, it takes the slot at a round-robin pointer. The pointer is 0 after reset and moves to the next slot, wrapping at the last one, on each eviction only. A check on the evicted tag then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Record a hoisted load this cycle |
| ld_tag | input | 7 | Destination register tag of the hoisted load |
| ld_addr | input | 64 | Byte address of the hoisted load |
| st_valid | input | 1 | A store is observed this cycle |
| st_addr | input | 64 | Byte address of the store |
| chk_valid | input | 1 | Check request this cycle |
| chk_tag | input | 7 | Register tag to check |
| rsp_valid | output | 1 | Check response pulse, one cycle after the request |
| rsp_ok | output | 1 | 1: record live (load is safe); 0: cancelled or missing |

## Verification
Directed sequences each isolate one effect:
- A store in the same granule but at another byte offset, compared with a store to the neighbouring granule, separates granule matching from exact address matching.
- Re-inserting a tag at a new address, followed by stores to the old and then the new address, separates overwrite from duplicate allocation.
- A store and an insert in the same cycle expose the order in which the two are applied.
- A check in the same cycle as the insert it refers to shows that the lookup sees the state before that cycle's updates.
- Filling all eight slots and then adding new tags shows which record the round-robin pointer evicts.

A long random phase then draws from a small pool of tags and granules. This forces frequent tag reuse, store hits, full-table evictions and overlapping operations. Every cycle is compared against a behavioural table model.

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES  = 8,
  parameter int TAG_W    = 7,
  parameter int ADDR_W   = 64,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              rsp_valid,
  output logic              rsp_ok
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]             ent_v;
  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [IDX_W-1:0]               rr_ptr;

  logic [ENTRIES-1:0] st_hit, v_after, tag_hit, chk_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign st_hit[i]  = st_valid && ent_v[i] &&
                        (ent_addr[i][ADDR_W-1:GRAN_LSB] == st_addr[ADDR_W-1:GRAN_LSB]);
    assign v_after[i] = ent_v[i] && !st_hit[i];
    assign tag_hit[i] = v_after[i] && (ent_tag[i] == ld_tag);
    assign chk_hit[i] = ent_v[i] && (ent_tag[i] == chk_tag);
  end

  logic             any_tag_hit, any_free, full;
  logic [IDX_W-1:0] hit_idx, free_idx, ins_idx;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_hit[i]) hit_idx = IDX_W'(i);
      if (!v_after[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign any_tag_hit = |tag_hit;
  assign full        = !any_free;
  assign ins_idx     = any_tag_hit ? hit_idx : (full ? rr_ptr : free_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v     <= '0;
      rr_ptr    <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      ent_v <= v_after;
      if (ld_valid) begin
        ent_v[ins_idx]    <= 1'b1;
        ent_tag[ins_idx]  <= ld_tag;
        ent_addr[ins_idx] <= ld_addr;
        if (!any_tag_hit && full)
          rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
      rsp_valid <= chk_valid;
      rsp_ok    <= chk_valid && (|chk_hit);
    end
  end
endmodule

// File: rtl/spec_load_table_checks.sv
module spec_load_table_checks #(
  parameter int ENTRIES  = 8,
  parameter int TAG_W    = 7,
  parameter int ADDR_W   = 64,
  parameter int GRAN_LSB = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ld_valid,
  input logic [TAG_W-1:0]                 ld_tag,
  input logic [ADDR_W-1:0]                ld_addr,
  input logic                             st_valid,
  input logic [ADDR_W-1:0]                st_addr,
  input logic                             chk_valid,
  input logic [TAG_W-1:0]                 chk_tag,
  input logic                             rsp_valid,
  input logic                             rsp_ok,
  input logic [ENTRIES-1:0]               ent_v,
  input logic [ENTRIES-1:0][TAG_W-1:0]    ent_tag,
  input logic [ENTRIES-1:0][ADDR_W-1:0]   ent_addr
);
  logic                     st_q, ld_same_q;
  logic [ADDR_W-1:GRAN_LSB] st_gran_q;
  logic                     dup, survivor;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= 1'b0;
      ld_same_q <= 1'b0;
      st_gran_q <= '0;
    end else begin
      st_q      <= st_valid;
      st_gran_q <= st_addr[ADDR_W-1:GRAN_LSB];
      ld_same_q <= ld_valid && (ld_addr[ADDR_W-1:GRAN_LSB] == st_addr[ADDR_W-1:GRAN_LSB]);
    end
  end

  always_comb begin
    dup      = 1'b0;
    survivor = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_v[i] && ent_addr[i][ADDR_W-1:GRAN_LSB] == st_gran_q) survivor = 1'b1;
      for (int j = i + 1; j < ENTRIES; j++)
        if (ent_v[i] && ent_v[j] && ent_tag[i] == ent_tag[j]) dup = 1'b1;
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) chk_valid |=> rsp_valid); // R2
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !chk_valid |=> !rsp_valid); // R2
  AST_OK_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> !rsp_ok); // R2
  AST_INSERT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid ##1 (chk_valid && chk_tag == $past(ld_tag)) |=> rsp_ok); // R3
  AST_STORE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !ld_same_q) |-> !survivor); // R4
  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n) !dup); // R5
endmodule

bind spec_load_table spec_load_table_checks #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
) u_chk (.*);

// File: tb/spec_load_table_test.sv
module spec_load_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
  logic [6:0]  ld_tag = '0, chk_tag = '0;
  logic [63:0] ld_addr = '0, st_addr = '0;
  logic        rsp_valid, rsp_ok;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  bit          m_v[8];
  logic [6:0]  m_tag[8];
  logic [63:0] m_addr[8];
  int          m_ptr;
  logic        exp_rv, exp_ok;

  always #10 clk = ~clk;

  spec_load_table uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr), .chk_valid(chk_valid), .chk_tag(chk_tag),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok));

  task automatic compare(string req);
    vectors++;
    if (rsp_valid !== exp_rv || rsp_ok !== exp_ok) begin
      miscompares++;
      $display("FAIL %s: rsp_valid/rsp_ok = %b/%b, expected %b/%b at %0t",
               req, rsp_valid, rsp_ok, exp_rv, exp_ok, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ld_valid = 0; st_valid = 0; chk_valid = 0;
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    m_ptr = 0; exp_rv = 0; exp_ok = 0;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic step(bit ld, logic [6:0] lt, logic [63:0] la, bit st, logic [63:0] sa,
                      bit ck, logic [6:0] ct, string req);
    int slot;
    ld_valid = ld; ld_tag = lt; ld_addr = la;
    st_valid = st; st_addr = sa; chk_valid = ck; chk_tag = ct;
    exp_rv = ck; exp_ok = 0;
    if (ck) for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == ct) exp_ok = 1;
    if (st) for (int i = 0; i < 8; i++) if (m_v[i] && m_addr[i][63:3] == sa[63:3]) m_v[i] = 0;
    if (ld) begin
      slot = -1;
      for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == lt) slot = i;
      if (slot < 0) for (int i = 7; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % 8; end
      m_v[slot] = 1; m_tag[slot] = lt; m_addr[slot] = la;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic ins(logic [6:0] t, logic [63:0] a, string req); step(1, t, a, 0, 0, 0, 0, req); endtask
  task automatic sto(logic [63:0] a, string req); step(0, 0, 0, 1, a, 0, 0, req); endtask
  task automatic chk(logic [6:0] t, string req); step(0, 0, 0, 0, 0, 1, t, req); endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(7'd5, "R1");                            // empty table: miss
    chk(7'd5, "R1");
    ins(7'd5, 64'h1000, "R3");
    chk(7'd5, "R3"); chk(7'd5, "R3");           // pass, stays live
    sto(64'h1007, "R4"); chk(7'd5, "R4");       // same granule, other byte: cancelled
    ins(7'd6, 64'h2000, "R4");
    sto(64'h2008, "R4"); chk(7'd6, "R4");       // neighbour granule: survives
    ins(7'd7, 64'h3000, "R5"); ins(7'd7, 64'h4000, "R5");
    sto(64'h3000, "R5"); chk(7'd7, "R5");       // old address no longer relevant
    sto(64'h4000, "R5"); chk(7'd7, "R5");       // new address kills it
    step(1, 7'd9, 64'h5000, 1, 64'h5000, 0, 0, "R6");
    chk(7'd9, "R6");                            // store applied before insert
    step(1, 7'd10, 64'h6000, 0, 0, 1, 7'd10, "R2"); // check sees pre-state: miss
    chk(7'd10, "R2");
    step(0, 0, 0, 1, 64'h6000, 1, 7'd10, "R2"); // store same cycle: check still passes
    chk(7'd10, "R2");

    do_reset();
    for (int i = 0; i < 8; i++) ins(7'(20 + i), 64'(32'h10000 + i * 64), "R7");
    ins(7'd28, 64'h20000, "R7");                // evicts tag 20 (slot 0)
    chk(7'd20, "R7"); chk(7'd21, "R7"); chk(7'd28, "R7");
    ins(7'd29, 64'h20040, "R7");                // evicts tag 21 (slot 1)
    chk(7'd21, "R7"); chk(7'd22, "R7");
    sto(64'h10080, "R7");                       // frees slot 2 (tag 22)
    ins(7'd30, 64'h30000, "R7");                // takes free slot, pointer unchanged
    chk(7'd23, "R7"); chk(7'd30, "R7");
    ins(7'd31, 64'h30040, "R7");                // evicts slot 2 (tag 30)
    chk(7'd30, "R7"); chk(7'd31, "R7");

    do_reset();
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 3) == 0, 7'($urandom % 12), {57'($urandom % 16), 7'($urandom % 128)} >> 1,
           ($urandom % 4) == 0, {57'($urandom % 16), 7'($urandom % 128)} >> 1,
           ($urandom % 2) == 0, 7'($urandom % 12), "R2");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule